// File: doc/BRIEF.md
# Gated Clock Output Slice

This block builds one gated output clock from up to six candidate source clocks. A 32-bit control word chooses the source. It starts and stops the output on whole source cycles and can force the output low at any moment. It can also hold back the start by a few source cycles and slip the running output by one source cycle on request. The block does no frequency division and no glitch-free handover between sources. Changing the source select while the output is running switches the multiplexer directly.

The enable crosses into the selected source domain through a two-stage synchroniser. It then passes a short shift register, and the programmed phase setting picks the tap. A register clocked on the falling source edge gates the output, so a change of enable can never cut a high phase short. A change of level on the nudge control is synchronised and detected in the source domain. The gate then blanks exactly one source high phase. The kill control acts asynchronously: it clears the enable chain and the gate and masks the output at once.

Top module: `clkgen_slice`

## Requirements
- R1: The select field, control word bits 7:5, picks source 0 to 5 with codes 0 to 5. The output follows only the selected source, and edges on any other source leave it low.
- R2: Select codes 6 and 7 choose no clock, and the output stays low while every source toggles.
- R3: Enable is control word bit 11. With a phase setting of 0, the first output high phase is the one that starts at the 3rd selected-source rising edge after enable is set. After enable is cleared, exactly 2 more full high phases appear. The output is low in every low half of the source.
- R4: The phase setting, control word bits 17:16, adds p = 0 to 3 source cycles. Start comes at rising edge 3+p after enable is set, and 2+p high phases follow the clearing of enable.
- R5: A phase setting written while the output runs does not change the current output. The start and stop latency in force keeps the value captured when the output was last idle.
- R6: Nudge is control word bit 20. Each change of its level, rising or falling, made while the output runs removes exactly the high phase at the 4th selected-source rising edge after the change. Every other high phase is kept.
- R7: Kill is control word bit 10. While it is high the output is low, and setting it in the middle of a high phase drops the output without waiting for a source edge.
- R8: After kill is released with enable still set, the output restarts like a fresh enable: the first high phase comes at the 3rd source rising edge (phase 0).
- R9: The synchronous active-high reset, held over at least 3 source rising edges, leaves the output low. After reset, an all-zero control word gives a disabled output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | NSRC (6) | Candidate source clocks |
| rst | input | 1 | Synchronous active-high reset, sampled on the selected source |
| ctrl_word | input | 32 | Control word: select, kill, enable, phase, nudge |
| clk_out | output | 1 | Gated output clock |

## Verification
Each result is due a fixed number of selected-source rising edges after a control change: edge 3+p for a start, 2+p further high phases after a stop, edge 4 for the phase slip after a nudge, and zero edges for kill. The bench writes control values only in the source low half. It produces every source cycle itself and samples the output 5 ns into each high half and each low half, so each expected value sits in the queue at the exact source cycle it belongs to. The kill check is also made partway through a high half, 1 ns after kill rises.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int CW_W      = 32;
    localparam int SEL_W     = 3;
    localparam int SEL_LSB   = 5;
    localparam int KILL_BIT  = 10;
    localparam int EN_BIT    = 11;
    localparam int PH_W      = 2;
    localparam int PH_LSB    = 16;
    localparam int NUDGE_BIT = 20;
    localparam int MAX_PHASE = (1 << PH_W) - 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             kill;
        logic             en;
        logic [PH_W-1:0]  phase;
        logic             nudge;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CW_W-1:0] w);
        ctrl_t c;
        c.sel   = w[SEL_LSB +: SEL_W];
        c.kill  = w[KILL_BIT];
        c.en    = w[EN_BIT];
        c.phase = w[PH_LSB +: PH_W];
        c.nudge = w[NUDGE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/clkgen_src_mux.sv
module clkgen_src_mux
    import clkgen_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0]  src_clk,
    input  logic [SEL_W-1:0] sel,
    output logic             sclk
);
    // Codes at or above NSRC match no input and leave the clock at zero.
    always_comb begin
        sclk = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) sclk = src_clk[i];
        end
    end
endmodule

// File: rtl/clkgen_en_path.sv
module clkgen_en_path
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            sclk,
    input  logic            rst,
    input  logic            kill,
    input  logic            en_in,
    input  logic [PH_W-1:0] phase_in,
    output logic            en_tap
);
    localparam int NTAPS = MAX_PHASE + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [MAX_PHASE-1:0]   dly_q;
    logic [PH_W-1:0]        phase_q;
    logic [NTAPS-1:0]       taps;
    logic                   idle;

    assign idle = !sync_q[SYNC_STAGES-1] && (dly_q == '0);
    assign taps = {dly_q, sync_q[SYNC_STAGES-1]};
    assign en_tap = taps[phase_q];

    always_ff @(posedge sclk or posedge kill) begin
        if (kill) begin
            sync_q <= '0;
            dly_q  <= '0;
        end else if (rst) begin
            sync_q  <= '0;
            dly_q   <= '0;
            phase_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], en_in};
            dly_q  <= {dly_q[MAX_PHASE-2:0], sync_q[SYNC_STAGES-1]};
            if (idle) phase_q <= phase_in;
        end
    end

    // Phase setting is frozen while the synchronised enable is up.
    a_r5_phase_frozen: assert property (@(posedge sclk) disable iff (rst || kill)
        sync_q[SYNC_STAGES-1] |=> $stable(phase_q));
endmodule

// File: rtl/clkgen_nudge.sv
module clkgen_nudge
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic sclk,
    input  logic rst,
    input  logic kill,
    input  logic nudge_in,
    output logic skip
);
    logic [SYNC_STAGES-1:0] nsync_q;
    logic                   nprev_q;
    logic                   skip_q;
    logic                   edge_seen;

    assign edge_seen = nsync_q[SYNC_STAGES-1] ^ nprev_q;
    assign skip = skip_q;

    always_ff @(posedge sclk) begin
        if (rst) begin
            nsync_q <= '0;
            nprev_q <= 1'b0;
        end else begin
            nsync_q <= {nsync_q[SYNC_STAGES-2:0], nudge_in};
            nprev_q <= nsync_q[SYNC_STAGES-1];
        end
    end

    always_ff @(posedge sclk or posedge kill) begin
        if (kill)     skip_q <= 1'b0;
        else if (rst) skip_q <= 1'b0;
        else          skip_q <= edge_seen;
    end

    // One level change blanks one cycle, never two in a row.
    a_r6_single_slip: assert property (@(posedge sclk) disable iff (rst || kill)
        skip_q |=> !skip_q);
endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate (
    input  logic sclk,
    input  logic rst,
    input  logic kill,
    input  logic en_tap,
    input  logic skip,
    output logic clk_out
);
    logic gate_q;

    // Updated only while the source is low, so high phases are never cut.
    always_ff @(negedge sclk or posedge kill) begin
        if (kill)     gate_q <= 1'b0;
        else if (rst) gate_q <= 1'b0;
        else          gate_q <= en_tap && !skip;
    end

    assign clk_out = sclk && gate_q && !kill;

    a_r3_gate_after_sync: assert property (@(negedge sclk) disable iff (rst || kill)
        $rose(gate_q) |-> $past(en_tap));
endmodule

// File: rtl/clkgen_slice.sv
module clkgen_slice
    import clkgen_pkg::*;
#(
    parameter int NSRC        = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic [NSRC-1:0] src_clk,
    input  logic            rst,
    input  logic [CW_W-1:0] ctrl_word,
    output logic            clk_out
);
    ctrl_t ctl;
    logic  sclk;
    logic  en_tap;
    logic  skip;

    assign ctl = decode_ctrl(ctrl_word);

    clkgen_src_mux #(.NSRC(NSRC)) u_mux (
        .src_clk (src_clk),
        .sel     (ctl.sel),
        .sclk    (sclk)
    );

    clkgen_en_path #(.SYNC_STAGES(SYNC_STAGES)) u_en (
        .sclk     (sclk),
        .rst      (rst),
        .kill     (ctl.kill),
        .en_in    (ctl.en),
        .phase_in (ctl.phase),
        .en_tap   (en_tap)
    );

    clkgen_nudge #(.SYNC_STAGES(SYNC_STAGES)) u_nudge (
        .sclk     (sclk),
        .rst      (rst),
        .kill     (ctl.kill),
        .nudge_in (ctl.nudge),
        .skip     (skip)
    );

    clkgen_gate u_gate (
        .sclk    (sclk),
        .rst     (rst),
        .kill    (ctl.kill),
        .en_tap  (en_tap),
        .skip    (skip),
        .clk_out (clk_out)
    );

    always_comb begin
        if (ctl.kill) begin
            a_r7_kill_low: assert (clk_out == 1'b0);
        end
    end
endmodule

// File: tb/clkgen_slice_tb.sv
module clkgen_slice_tb;
    localparam int HALF = 10; // 50 MHz sources

    typedef struct {
        logic  v;
        string tag;
    } exp_t;

    logic [5:0]  src_clk = '0;
    logic        rst = 1'b1;
    logic [31:0] ctrl_word = '0;
    logic        clk_out;

    int   checks = 0;
    int   fails  = 0;
    exp_t exp_q[$];
    event smp_ev;

    clkgen_slice u_dut (
        .src_clk   (src_clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .clk_out   (clk_out)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: clk_out=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Monitor: pops one expected value per sample point.
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                chk(clk_out, it.v, it.tag);
            end
        end
    end

    // Driver: one full source cycle on the sources in mask.
    task automatic tick(input logic [5:0] mask, input logic exp_hi, input string tag);
        exp_t a;
        exp_t b;
        src_clk = mask;
        #5;
        a.v = exp_hi; a.tag = tag;
        exp_q.push_back(a);
        -> smp_ev;
        #5;
        src_clk = '0;
        #5;
        b.v = 1'b0; b.tag = tag;
        exp_q.push_back(b);
        -> smp_ev;
        #5;
    endtask

    task automatic run(input logic [5:0] mask, input int n, input logic v, input string tag);
        for (int i = 0; i < n; i++) tick(mask, v, tag);
    endtask

    task automatic set_ctl(input int sel, input logic kill, input logic en,
                           input int ph, input logic nudge);
        ctrl_word = '0;
        ctrl_word[7:5]   = 3'(sel);
        ctrl_word[10]    = kill;
        ctrl_word[11]    = en;
        ctrl_word[17:16] = 2'(ph);
        ctrl_word[20]    = nudge;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R9: reset state
        run(6'h01, 3, 1'b0, "R9");
        rst = 1'b0;
        run(6'h01, 3, 1'b0, "R9");

        // R3: start and stop with phase 0
        set_ctl(0, 0, 1, 0, 0);
        run(6'h01, 2, 1'b0, "R3");
        run(6'h01, 3, 1'b1, "R3");
        set_ctl(0, 0, 0, 0, 0);
        run(6'h01, 2, 1'b1, "R3");
        run(6'h01, 2, 1'b0, "R3");

        // R4: phase settings 1..3
        for (int p = 1; p <= 3; p++) begin
            set_ctl(0, 0, 1, p, 0);
            run(6'h01, 2 + p, 1'b0, "R4");
            run(6'h01, 2, 1'b1, "R4");
            set_ctl(0, 0, 0, p, 0);
            run(6'h01, 2 + p, 1'b1, "R4");
            run(6'h01, 2, 1'b0, "R4");
        end

        // R5: phase change while running is ignored
        set_ctl(0, 0, 0, 0, 0);
        run(6'h01, 2, 1'b0, "R5");
        set_ctl(0, 0, 1, 0, 0);
        run(6'h01, 2, 1'b0, "R5");
        run(6'h01, 2, 1'b1, "R5");
        set_ctl(0, 0, 1, 3, 0);
        run(6'h01, 3, 1'b1, "R5");
        set_ctl(0, 0, 0, 3, 0);
        run(6'h01, 2, 1'b1, "R5");
        run(6'h01, 5, 1'b0, "R5");

        // R6: nudge slips one cycle on each edge
        set_ctl(0, 0, 0, 0, 0);
        run(6'h01, 2, 1'b0, "R6");
        set_ctl(0, 0, 1, 0, 0);
        run(6'h01, 2, 1'b0, "R6");
        run(6'h01, 2, 1'b1, "R6");
        set_ctl(0, 0, 1, 0, 1);
        run(6'h01, 3, 1'b1, "R6");
        tick(6'h01, 1'b0, "R6");
        run(6'h01, 2, 1'b1, "R6");
        set_ctl(0, 0, 1, 0, 0);
        run(6'h01, 3, 1'b1, "R6");
        tick(6'h01, 1'b0, "R6");
        run(6'h01, 2, 1'b1, "R6");

        // R7: kill in the middle of a high phase
        src_clk = 6'h01;
        #3;
        chk(clk_out, 1'b1, "R7");
        set_ctl(0, 1, 1, 0, 0);
        #1;
        chk(clk_out, 1'b0, "R7");
        #6;
        src_clk = '0;
        #10;
        run(6'h01, 2, 1'b0, "R7");

        // R8: release of kill restarts like a fresh enable
        set_ctl(0, 0, 1, 0, 0);
        run(6'h01, 2, 1'b0, "R8");
        run(6'h01, 2, 1'b1, "R8");

        // R1: source select
        set_ctl(2, 0, 1, 0, 0);
        tick(6'h04, 1'b1, "R1");
        tick(6'h01, 1'b0, "R1");
        tick(6'h04, 1'b1, "R1");
        tick(6'h3B, 1'b0, "R1");

        // R2: reserved codes select nothing
        set_ctl(6, 0, 1, 0, 0);
        run(6'h3F, 2, 1'b0, "R2");
        set_ctl(7, 0, 1, 0, 0);
        run(6'h3F, 2, 1'b0, "R2");
        set_ctl(5, 0, 1, 0, 0);
        tick(6'h20, 1'b1, "R1");

        // R9: reset while running, then restart
        rst = 1'b1;
        tick(6'h20, 1'b1, "R9");
        run(6'h20, 2, 1'b0, "R9");
        rst = 1'b0;
        run(6'h20, 2, 1'b0, "R9");
        tick(6'h20, 1'b1, "R9");

        #20;
        summary();
        $finish;
    end
endmodule